// File: doc/BRIEF.md
# Programmable One-Shot and Periodic Event Timer

A 29-bit down-counter that advances on a one-microsecond tick enable supplied from outside the block. Software arms it through a control word. That word carries the reload value in its low bits, a run bit and a repeat bit. When the counter is at zero and a tick arrives, the timer raises a level-high interrupt. That interrupt stays up until software writes a clear request to the second register.

With the repeat bit clear, the timer fires once and then disarms itself. With the repeat bit set, it reloads the programmed value and keeps firing every N+1 ticks. Loading N therefore gives an event after N+1 ticks, so a load of zero fires on the first tick.

Top module: `event_timer`

## Requirements
- R1: After reset, irq is low, both registers read as zero and the timer is disarmed.
- R2: Address 0 is the control word. Bit 31 is run, bit 30 is repeat and bits [28:0] are the reload value. Bit 29 is ignored on write and reads back as zero. Reading address 0 returns the live run bit, the repeat bit and the reload value.
- R3: After a control write with run set and value N, irq rises right after the (N+1)-th tick. The count drops by one on each tick while armed. Ticks have no effect while disarmed.
- R4: In one-shot mode, expiry clears the run bit. The count then stays at zero and no further event is raised.
- R5: In repeat mode, expiry reloads the count with N, and the next event follows N+1 ticks later.
- R6: irq is a level that stays high until a write to address 1 with bit 30 set. A write to address 1 with bit 30 clear has no effect.
- R7: Reading address 1 returns the current count in bits [28:0] and the event flag in bit 30. All other bits read as zero.
- R8: A control write while the timer is running reloads the count at once and applies the new mode bits. Writing zero stops the timer.
- R9: When an expiry and a clear request fall in the same cycle, the flag stays set. When a control write and a tick fall in the same cycle, the written value is kept.
- R10: The largest reload value, 0x1FFFFFFF, loads and counts down without wrap or truncation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | One-cycle pulse per microsecond tick |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 1 | 0 selects the control word, 1 selects status/clear |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Event interrupt, active high level |

## Verification
The bench sweeps reload values from 0 upward in both modes and counts ticks to the event. A design with an off-by-one would fire after N or N+2 ticks, and one that failed to reload would drift or stall in repeat mode. It also goes after same-cycle collisions. A clear that beats an expiry would lose an event, and a tick that beats a control write would leave a count one too low. Further cases cover the all-ones load, stray writes to the ignored bit and a clear without bit 30. These would expose a truncated field, a leaked reserved bit or a clear decoded from the wrong bit.

// File: rtl/event_timer.sv
module event_timer #(
  parameter int CNT_W    = 29,
  parameter int RUN_BIT  = 31,
  parameter int REP_BIT  = 30,
  parameter int FLAG_BIT = 30
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        bus_we,
  input  logic        bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);

  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] load_q, cnt_q;
  logic             run_q, rep_q, flag_q;

  wire ctrl_wr = bus_we && !bus_addr;
  wire clr_req = bus_we && bus_addr && bus_wdata[FLAG_BIT];
  wire step    = tick_en && run_q && !ctrl_wr;
  wire expire  = step && (cnt_q == ZERO);

  logic unused_gap;
  assign unused_gap = ^bus_wdata[REP_BIT-1:CNT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      rep_q  <= 1'b0;
    end else if (ctrl_wr) begin
      load_q <= bus_wdata[CNT_W-1:0];
      cnt_q  <= bus_wdata[CNT_W-1:0];
      run_q  <= bus_wdata[RUN_BIT];
      rep_q  <= bus_wdata[REP_BIT];
    end else if (expire) begin
      if (rep_q) cnt_q <= load_q;
      else       run_q <= 1'b0;
    end else if (step) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (expire)  flag_q <= 1'b1;
    else if (clr_req) flag_q <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr) begin
      bus_rdata[CNT_W-1:0] = cnt_q;
      bus_rdata[FLAG_BIT]  = flag_q;
    end else begin
      bus_rdata[CNT_W-1:0] = load_q;
      bus_rdata[RUN_BIT]   = run_q;
      bus_rdata[REP_BIT]   = rep_q;
    end
  end

  assign irq = flag_q;

  assert_irq_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tick_en && run_q && cnt_q == ZERO));

  assert_irq_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_we && bus_addr && bus_wdata[FLAG_BIT]));

  assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_wr && !(tick_en && run_q)) |=> $stable(cnt_q));

  assert_oneshot_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !rep_q) |=> !run_q && cnt_q == ZERO);

  assert_periodic_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && rep_q) |=> run_q && cnt_q == $past(load_q));

  assert_ctrl_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> cnt_q == $past(bus_wdata[CNT_W-1:0]));

endmodule

// File: tb/event_timer_bench.sv
module event_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_we = 1'b0;
  logic        bus_addr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;

  localparam logic [31:0] CLR   = 32'h4000_0000;
  localparam logic [31:0] ONE   = 32'h8000_0000;
  localparam logic [31:0] REP   = 32'hC000_0000;
  localparam logic [31:0] SMASK = 32'h5FFF_FFFF;

  always #2.5 clk = ~clk;

  event_timer u_event_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic a, output logic [31:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finish_up();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(irq == 1'b0, "R1 irq", {31'd0, irq}, 32'd0);
    rd(1'b1, v); chk(v == 32'd0, "R1 status", v, 32'd0);
    rd(1'b0, v); chk(v == 32'd0, "R1 control", v, 32'd0);

    // R3 ticks ignored while disarmed
    wr(1'b0, 32'h0000_0005);
    repeat (4) tick();
    rd(1'b1, v); chk(v == 32'd5, "R3 disarmed count", v, 32'd5);

    // R3/R4/R7 one-shot sweep
    for (int n = 0; n <= 20; n++) begin
      wr(1'b0, ONE | n);
      for (int k = 0; k <= n; k++) begin
        rd(1'b1, v);
        chk(v == 32'(n - k), "R3 count", v, 32'(n - k));
        tick();
      end
      rd(1'b1, v);
      chk(v == CLR, "R7 status after expiry", v, CLR);
      chk(irq == 1'b1, "R3 irq after n+1", {31'd0, irq}, 32'd1);
      rd(1'b0, v);
      chk(v == 32'(n), "R4 run cleared", v, 32'(n));
      repeat (3) tick();
      rd(1'b1, v); chk(v == CLR, "R4 stays at zero", v, CLR);
      wr(1'b1, CLR);
      chk(irq == 1'b0, "R6 clear", {31'd0, irq}, 32'd0);
      repeat (3) tick();
      chk(irq == 1'b0, "R4 no second event", {31'd0, irq}, 32'd0);
    end

    // R5 repeat sweep
    for (int n = 0; n <= 9; n++) begin
      wr(1'b0, REP | n);
      for (int p = 0; p < 3; p++) begin
        for (int k = 0; k <= n; k++) begin
          chk(irq == 1'b0, "R5 early irq", {31'd0, irq}, 32'd0);
          tick();
        end
        rd(1'b1, v);
        chk(v == (CLR | n), "R5 reload and flag", v, CLR | n);
        wr(1'b1, CLR);
      end
      wr(1'b0, 32'd0);
      repeat (3) tick();
      rd(1'b1, v);
      chk(v == 32'd0, "R8 write zero stops", v, 32'd0);
    end

    // R6 clear without bit 30 ignored
    wr(1'b0, ONE);
    tick();
    wr(1'b1, 32'hBFFF_FFFF);
    chk(irq == 1'b1, "R6 clear bit30 low ignored", {31'd0, irq}, 32'd1);
    rd(1'b1, v); chk((v & ~SMASK) == 32'd0, "R7 reserved bits", v, v & SMASK);
    wr(1'b1, CLR);
    chk(irq == 1'b0, "R6 clear bit30 high", {31'd0, irq}, 32'd0);

    // R8 rewrite while running
    wr(1'b0, ONE | 32'd10);
    repeat (3) tick();
    rd(1'b1, v); chk(v == 32'd7, "R8 running count", v, 32'd7);
    wr(1'b0, REP | 32'd4);
    rd(1'b1, v); chk(v == 32'd4, "R8 reload now", v, 32'd4);
    rd(1'b0, v); chk(v == (REP | 32'd4), "R2 control readback", v, REP | 32'd4);
    repeat (5) tick();
    rd(1'b1, v); chk(v == (CLR | 32'd4), "R8 new mode applied", v, CLR | 32'd4);
    wr(1'b1, CLR);
    wr(1'b0, 32'd0);

    // R2/R10 all ones, bit 29 dropped
    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b0, v); chk(v == 32'hDFFF_FFFF, "R2 bit29 ignored", v, 32'hDFFF_FFFF);
    rd(1'b1, v); chk(v == 32'h1FFF_FFFF, "R10 max load", v, 32'h1FFF_FFFF);
    tick();
    rd(1'b1, v); chk(v == 32'h1FFF_FFFE, "R10 max step", v, 32'h1FFF_FFFE);
    chk(irq == 1'b0, "R10 no event", {31'd0, irq}, 32'd0);
    wr(1'b0, 32'd0);

    // R9 expiry and clear in one cycle
    wr(1'b0, ONE);
    @(negedge clk); tick_en = 1'b1; bus_we = 1'b1; bus_addr = 1'b1; bus_wdata = CLR;
    @(negedge clk); tick_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    chk(irq == 1'b1, "R9 set beats clear", {31'd0, irq}, 32'd1);
    wr(1'b1, CLR);

    // R9 control write and tick in one cycle
    wr(1'b0, ONE | 32'd3);
    @(negedge clk); tick_en = 1'b1; bus_we = 1'b1; bus_addr = 1'b0; bus_wdata = ONE | 32'd6;
    @(negedge clk); tick_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    rd(1'b1, v); chk(v == 32'd6, "R9 write beats tick", v, 32'd6);
    wr(1'b0, 32'd0);

    finish_up();
  end
endmodule